// File: doc/BRIEF.md
# SMBus Byte-Register Slave

This block is a serial-bus slave that gives a host byte-wide access to eight 8-bit registers. It receives SCL and SDA as open-drain lines, samples them on the system clock through a synchronizer, and pulls SDA low through a single output whenever it has to drive a zero. Three forms of transfer are handled: a byte write (address with write bit, command, data), a byte read (address with write bit, command, repeated START, address with read bit, one returned byte) and a bare receive (address with read bit, one returned byte).

The command byte picks the register and is kept in a pointer that survives between transfers. A bare receive therefore returns whichever register the last command byte selected. The upper four bits of the 7-bit slave address are fixed. The lower three come from strap pins that are sampled while reset is held, which stands in for power-up. The registers sit in a small memory with one write port and one registered read port.

Top module: `smb_regslave`

## Requirements
- R1: The slave answers only to the 7-bit address 1000 followed by the three latched strap bits, with the strap bit 2 as the most significant of the three. An address byte whose upper seven bits differ is not acknowledged, and SDA stays released for the rest of that transfer.
- R2: The strap bits are captured only while `rst` is high. Strap changes after reset has been released have no effect on the address the slave answers to.
- R3: A byte write with command 00h–07h stores the data byte in the register that the command selects.
- R4: A byte read with command 00h–07h returns the current contents of the register that the command selects. The byte is sent most significant bit first.
- R5: A bare receive returns the register selected by the command byte of the most recent transfer that carried one.
- R6: A command byte of 08h or above is acknowledged but changes no register. A read at such a pointer returns 00h.
- R7: The slave acknowledges a matching address byte, every command byte and every write data byte by holding SDA low through the ninth clock.
- R8: After the master answers the returned data byte with a not-acknowledge, SDA stays released until the next START.
- R9: A STOP or START at any bit position returns the bit-level sequencer to its idle or address-receiving state. The pointer keeps its value through this.
- R10: The SDA pull-down changes only one cycle after a detected SCL falling edge, START or STOP. It is released during and after reset.
- R11: The write strobe to the register memory fires only for a pointer below 08h, and only on the cycle after an SCL falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; the strap bits are sampled while it is high |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| strap_i | input | 3 | Strap pins giving the three low slave address bits |
| sda_pull_o | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
The checker watches, on every cycle, that the SDA pull-down moves only after an SCL fall, START or STOP, and that a STOP always leaves SDA released. It also checks that the latched strap value never moves outside reset, and that memory writes happen only for valid pointers on the cycle after an SCL fall. Whether an address or byte is acknowledged, which register content comes back, and that the pointer survives aborted transfers can only be seen through the bench's bus transactions. The bench compares these against a model of the registers and the pointer, over directed and random sequences.

// File: rtl/smb_pkg.sv
package smb_pkg;

  typedef logic [7:0] byte_t;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_CMD,
    ST_CMD_ACK,
    ST_WDAT,
    ST_WDAT_ACK,
    ST_TX,
    ST_MACK,
    ST_SKIP
  } seq_state_t;

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  localparam int LAST = STAGES - 1;

  logic [LAST:0] scl_sh;
  logic [LAST:0] sda_sh;
  logic          scl_d;
  logic          sda_d;
  logic          scl_s;

  // Bus lines idle high, so every stage resets to 1.
  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[LAST-1:0], scl_i};
      sda_sh <= {sda_sh[LAST-1:0], sda_i};
      scl_d  <= scl_sh[LAST];
      sda_d  <= sda_sh[LAST];
    end
  end

  assign scl_s     = scl_sh[LAST];
  assign sda_s     = sda_sh[LAST];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/smb_reg_mem.sv
module smb_reg_mem #(
  parameter int AW = 3,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // One write port, one registered read port: maps onto block or distributed RAM.
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    rd_data <= mem[rd_addr];
  end

endmodule

// File: rtl/smb_byte_seq.sv
module smb_byte_seq
  import smb_pkg::*;
#(
  parameter int REG_AW = 3
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        sda_s,
  input  logic        scl_rise,
  input  logic        scl_fall,
  input  logic        start_det,
  input  logic        stop_det,
  input  logic [6:0]  dev_addr,
  input  byte_t       rd_data,
  output logic        sda_pull,
  output logic        wr_en,
  output byte_t       wr_data,
  output byte_t       ptr
);

  seq_state_t  state;
  byte_t       shreg;
  byte_t       txreg;
  logic [2:0]  cnt;
  logic        full;
  logic        is_read;
  logic        ptr_ok;
  byte_t       rd_val;

  assign ptr_ok = (ptr >> REG_AW) == '0;
  assign rd_val = ptr_ok ? rd_data : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      shreg    <= '0;
      txreg    <= '0;
      cnt      <= '0;
      full     <= 1'b0;
      is_read  <= 1'b0;
      ptr      <= '0;
      sda_pull <= 1'b0;
      wr_en    <= 1'b0;
      wr_data  <= '0;
    end else begin
      wr_en <= 1'b0;
      if (start_det) begin
        state    <= ST_ADDR;
        cnt      <= '0;
        full     <= 1'b0;
        sda_pull <= 1'b0;
      end else if (stop_det) begin
        state    <= ST_IDLE;
        cnt      <= '0;
        full     <= 1'b0;
        sda_pull <= 1'b0;
      end else begin
        unique case (state)
          ST_ADDR, ST_CMD, ST_WDAT: begin
            if (scl_rise) begin
              shreg <= {shreg[6:0], sda_s};
              cnt   <= cnt + 3'd1;
              if (cnt == 3'd7) full <= 1'b1;
            end else if (scl_fall && full) begin
              full <= 1'b0;
              cnt  <= '0;
              if (state == ST_ADDR) begin
                if (shreg[7:1] == dev_addr) begin
                  sda_pull <= 1'b1;
                  is_read  <= shreg[0];
                  state    <= ST_ADDR_ACK;
                end else begin
                  state <= ST_SKIP;
                end
              end else if (state == ST_CMD) begin
                ptr      <= shreg;
                sda_pull <= 1'b1;
                state    <= ST_CMD_ACK;
              end else begin
                wr_en    <= ptr_ok;
                wr_data  <= shreg;
                sda_pull <= 1'b1;
                state    <= ST_WDAT_ACK;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall) begin
              if (is_read) begin
                txreg    <= rd_val;
                sda_pull <= ~rd_val[7];
                cnt      <= '0;
                state    <= ST_TX;
              end else begin
                sda_pull <= 1'b0;
                state    <= ST_CMD;
              end
            end
          end
          ST_CMD_ACK: begin
            if (scl_fall) begin
              sda_pull <= 1'b0;
              state    <= ST_WDAT;
            end
          end
          ST_WDAT_ACK: begin
            if (scl_fall) begin
              sda_pull <= 1'b0;
              state    <= ST_SKIP;
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (cnt == 3'd7) begin
                sda_pull <= 1'b0;
                state    <= ST_MACK;
              end else begin
                cnt      <= cnt + 3'd1;
                txreg    <= {txreg[6:0], 1'b0};
                sda_pull <= ~txreg[6];
              end
            end
          end
          ST_MACK: begin
            if (scl_rise) state <= ST_SKIP;
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/smb_regslave.sv
module smb_regslave
  import smb_pkg::*;
#(
  parameter int                 REG_AW      = 3,
  parameter int                 SYNC_STAGES = 2,
  parameter int                 STRAP_W     = 3,
  parameter logic [6-STRAP_W:0] ADDR_HI     = 4'b1000
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               scl_i,
  input  logic               sda_i,
  input  logic [STRAP_W-1:0] strap_i,
  output logic               sda_pull_o
);

  logic               sda_s;
  logic               scl_rise;
  logic               scl_fall;
  logic               start_det;
  logic               stop_det;
  logic [STRAP_W-1:0] strap_q;
  logic [6:0]         dev_addr;
  logic               wr_en;
  byte_t              wr_data;
  byte_t              ptr;
  byte_t              rd_data;

  // Strap pins are sampled only while reset is held.
  always_ff @(posedge clk) begin
    if (rst) strap_q <= strap_i;
  end

  assign dev_addr = {ADDR_HI, strap_q};

  smb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst       (rst),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  smb_byte_seq #(.REG_AW(REG_AW)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .dev_addr  (dev_addr),
    .rd_data   (rd_data),
    .sda_pull  (sda_pull_o),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .ptr       (ptr)
  );

  smb_reg_mem #(.AW(REG_AW), .DW(8)) u_mem (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_addr (ptr[REG_AW-1:0]),
    .wr_data (wr_data),
    .rd_addr (ptr[REG_AW-1:0]),
    .rd_data (rd_data)
  );

endmodule

// File: rtl/smb_regslave_chk.sv
module smb_regslave_chk #(
  parameter int REG_AW  = 3,
  parameter int STRAP_W = 3
) (
  input logic               clk,
  input logic               rst,
  input logic               sda_pull_o,
  input logic               scl_fall,
  input logic               start_det,
  input logic               stop_det,
  input logic               wr_en,
  input logic [7:0]         ptr,
  input logic [STRAP_W-1:0] strap_q
);

  // R10: the pull-down only moves right after an SCL fall, START or STOP
  a_r10_pull_moves_on_event: assert property (@(posedge clk) disable iff (rst)
    (sda_pull_o != $past(sda_pull_o)) |-> $past(scl_fall || start_det || stop_det));

  // R9: a STOP leaves SDA released
  a_r9_stop_releases: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> !sda_pull_o);

  // R2: strap value frozen once reset is gone
  a_r2_strap_frozen: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> $stable(strap_q));

  // R11: write strobe only for an in-range pointer
  a_r11_write_in_range: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> ((ptr >> REG_AW) == 8'd0));

  // R11: write strobe follows an SCL fall
  a_r11_write_after_fall: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> $past(scl_fall));

endmodule

bind smb_regslave smb_regslave_chk #(.REG_AW(REG_AW), .STRAP_W(STRAP_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .sda_pull_o (sda_pull_o),
  .scl_fall   (scl_fall),
  .start_det  (start_det),
  .stop_det   (stop_det),
  .wr_en      (wr_en),
  .ptr        (ptr),
  .strap_q    (strap_q)
);

// File: tb/smb_regslave_bench.sv
module smb_regslave_bench;

  localparam int Q = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic [2:0] strap = 3'b101;
  logic       sda_pull;
  wire        sda_line = sda_m & ~sda_pull;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [7:0] model [8];
  logic [7:0] mptr = 8'd0;
  logic [6:0] dev;

  always #2.5 clk = ~clk;

  smb_regslave u_smb_regslave (
    .clk        (clk),
    .rst        (rst),
    .scl_i      (scl_m),
    .sda_i      (sda_line),
    .strap_i    (strap),
    .sda_pull_o (sda_pull)
  );

  function automatic logic [7:0] exp_read(logic [7:0] p);
    return (p < 8'd8) ? model[p[2:0]] : 8'h00;
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wq(int n);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic bus_start;
    sda_m = 1'b1; wq(1);
    scl_m = 1'b1; wq(1);
    sda_m = 1'b0; wq(1);
    scl_m = 1'b0; wq(1);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; wq(1);
    scl_m = 1'b1; wq(1);
    sda_m = 1'b1; wq(2);
  endtask

  task automatic send_bit(logic b);
    sda_m = b;    wq(1);
    scl_m = 1'b1; wq(2);
    scl_m = 1'b0; wq(1);
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; wq(1);
    scl_m = 1'b1; wq(1);
    b = sda_line; wq(1);
    scl_m = 1'b0; wq(1);
  endtask

  task automatic send_byte(logic [7:0] d, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    get_bit(ack);
  endtask

  task automatic recv_byte(output logic [7:0] d, input logic mack);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      d[i] = b;
    end
    send_bit(mack);
  endtask

  function automatic logic [6:0] other_addr();
    logic [6:0] a;
    do a = 7'($urandom); while (a == dev);
    return a;
  endfunction

  // Byte write; good selects the matching address
  task automatic t_write(logic [7:0] cmd, logic [7:0] data, bit good);
    logic ack;
    logic [6:0] a = good ? dev : other_addr();
    bus_start;
    send_byte({a, 1'b0}, ack);
    chk(good ? "R7 addr ack" : "R1 addr nack", {7'd0, ack}, good ? 8'd0 : 8'd1);
    if (good) begin
      send_byte(cmd, ack);
      chk("R7 cmd ack", {7'd0, ack}, 8'd0);
      mptr = cmd;
      send_byte(data, ack);
      chk("R7 data ack R6", {7'd0, ack}, 8'd0);
      if (cmd < 8'd8) model[cmd[2:0]] = data;
    end else begin
      send_byte(cmd, ack);
      chk("R1 ignored after nack", {7'd0, ack}, 8'd1);
    end
    bus_stop;
  endtask

  task automatic t_readbyte(logic [7:0] cmd, string req);
    logic ack;
    logic [7:0] d;
    bus_start;
    send_byte({dev, 1'b0}, ack);
    chk("R7 addr ack", {7'd0, ack}, 8'd0);
    send_byte(cmd, ack);
    chk("R7 cmd ack", {7'd0, ack}, 8'd0);
    mptr = cmd;
    bus_start;
    send_byte({dev, 1'b1}, ack);
    chk("R7 read addr ack", {7'd0, ack}, 8'd0);
    recv_byte(d, 1'b1);
    chk(req, d, exp_read(cmd));
    bus_stop;
  endtask

  task automatic t_receive(bit extra);
    logic ack;
    logic [7:0] d;
    bus_start;
    send_byte({dev, 1'b1}, ack);
    chk("R7 addr ack", {7'd0, ack}, 8'd0);
    recv_byte(d, 1'b1);
    chk("R5 receive pointer", d, exp_read(mptr));
    if (extra) begin
      recv_byte(d, 1'b1);
      chk("R8 released after nack", d, 8'hFF);
    end
    bus_stop;
  endtask

  task automatic summary;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (100 * 1000) @(posedge clk);
    repeat (50 * 1000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      summary;
      $finish;
    end
  end

  initial begin
    logic ack;
    int unsigned seed;
    seed = 32'h1F2E3D4C;
    void'($urandom(seed));
    dev = {4'b1000, 3'b101};
    for (int i = 0; i < 8; i++) model[i] = 8'h00;
    repeat (10) @(negedge clk);
    chk("R10 reset release", {7'd0, sda_pull}, 8'd0);
    rst = 1'b0;
    // R2: later strap change must be ignored
    strap = 3'b010;
    repeat (5) @(negedge clk);
    chk("R10 released after reset", {7'd0, sda_pull}, 8'd0);

    // R3 fill every register, R4 read each back
    for (int i = 0; i < 8; i++) t_write(8'(i), 8'(8'hA5 ^ (i * 37)), 1'b1);
    for (int i = 0; i < 8; i++) t_readbyte(8'(i), "R4 read byte");

    // R6 out-of-range command: acked, no change, reads 00h
    t_write(8'h09, 8'h3C, 1'b1);
    t_readbyte(8'hF0, "R6 read out of range");
    for (int i = 0; i < 8; i++) t_readbyte(8'(i), "R6 no register changed");

    // R5 receive after pointer set; R8 release after master nack
    t_readbyte(8'h05, "R4 read byte");
    t_receive(1'b1);

    // R9 STOP after command keeps pointer
    bus_start;
    send_byte({dev, 1'b0}, ack);
    send_byte(8'h02, ack);
    mptr = 8'h02;
    bus_stop;
    t_receive(1'b0);
    // R9 START in mid-address restarts cleanly
    bus_start;
    for (int i = 0; i < 4; i++) send_bit(1'b1);
    t_readbyte(8'h06, "R9 read after restart");

    // R2 new strap address not answered, old one is
    bus_start;
    send_byte({4'b1000, 3'b010, 1'b0}, ack);
    chk("R2 new strap nack", {7'd0, ack}, 8'd1);
    bus_stop;
    t_write(8'h01, 8'h77, 1'b1);

    // R1 wrong address is ignored
    t_write(8'h03, 8'hEE, 1'b0);
    t_readbyte(8'h03, "R1 wrong address wrote nothing");

    // Random mix
    for (int n = 0; n < 40; n++) begin
      int op = int'($urandom_range(0, 9));
      logic [7:0] c = 8'($urandom_range(0, 10));
      if (op < 4) t_write(c, 8'($urandom), op != 0);
      else if (op < 7) t_readbyte(c, "R4 random read");
      else t_receive(1'b0);
    end

    done = 1;
    summary;
    $finish;
  end

endmodule